// File: doc/BRIEF.md
# TRS Detector and Timing Generator

This block sits on a 10-bit parallel video word stream that carries one word per clock. It finds the timing reference sequences in that stream and derives line and field timing from them. In component mode it recognises the end-of-active-video and start-of-active-video sequences. In composite mode it recognises the five-word timing-reference-and-identification sequence. The stream is passed through a fixed four-stage delay. Every indicator is registered so that it lines up with the delayed word it describes.

The indicators are a horizontal sync, a vertical blanking flag, a three-bit field number, an ancillary-data marker and a missing-reference flag. The ancillary marker covers each component ancillary packet from its data ID word through its checksum word. When TRS marking is enabled, the same marker also covers the words of each timing sequence. The missing-reference flag uses hysteresis, so a single lost or spurious sequence cannot toggle it. Standard detection and checkword functions live elsewhere. The mode is chosen by a static input.

Top module: `trs_timing_gen`

## Requirements
- R1: `dout` equals the `din` word presented exactly four clock cycles earlier. While reset is held, `dout`, `hsync`, `vblank`, `field`, `anc` and `notrs` are all 0.
- R2: Words are classified on bits 9:2 only. Any word 3FC–3FF counts as 3FF, and any word 000–003 counts as 000, in every sequence the block recognises.
- R3: Component mode (`comp_mode`=1): a sequence is 3FF, 000, 000 followed by a code word, where code bit 4 is 1 for end-of-active and 0 for start-of-active. `hsync` goes to 1 on the output cycle that carries an end-of-active 3FF. It returns to 0 on the output cycle that carries a start-of-active 3FF.
- R4: Component mode: on the output cycle carrying any sequence's 3FF, `vblank` takes code bit 5 and `field` takes {0,0,code bit 6}. Both hold until the next sequence.
- R5: Composite mode (`comp_mode`=0): a sequence is 3FF, 000, 000, 000, ID. `hsync` is 1 for exactly one cycle, the output cycle carrying that 3FF.
- R6: Composite mode: from the output cycle carrying the word after the 3FF, `field` equals ID bits 2:0. On that same cycle, `vblank` is 1 exactly when the ID line code in bits 7:3 lies in 1..`CVB_LAST`. Both hold until the next sequence.
- R7: Component mode: after the header 000, 3FF, 3FF, `anc` is 1 for (data count bits 7:0) + 4 output cycles. The data count is the third word after the header. The marking starts on the data ID word, the first word after the header. In composite mode such a header does not drive `anc`.
- R8: With `mark_trs`=1, `anc` is also 1 for 4 output cycles from a component sequence's 3FF, or 5 from a composite one. With `mark_trs`=0, sequences never drive `anc`.
- R9: Time is cut into windows of `LINE_MAX` clocks, and a sequence restarts the window. A window that ends with no sequence is a miss. `notrs` rises on the seventh consecutive miss.
- R10: While `notrs` is 1, it falls on the seventh sequence received since the last miss. Any miss restarts that count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 10 | Incoming video word |
| comp_mode | input | 1 | 1 = component sequences, 0 = composite sequences |
| mark_trs | input | 1 | 1 = also mark timing sequences on `anc` |
| dout | output | 10 | Video word delayed by four clocks |
| hsync | output | 1 | Horizontal sync indicator |
| vblank | output | 1 | Vertical blanking indicator |
| field | output | 3 | Field number |
| anc | output | 1 | Ancillary data / sequence marker |
| notrs | output | 1 | Missing-reference flag |

## Verification
The packet marker and the sequence marker both drive `anc`, and they can be active on adjacent or overlapping cycles. To provoke this, the stimulus places an ancillary packet so that its checksum word directly precedes an end-of-active 3FF, and it also sends back-to-back packets. It does this with `mark_trs` both set and clear. The expected `anc` is built word by word from the packet lengths and the sequence positions. The check confirms that the marker neither drops for a cycle at the join nor runs past the last sequence word. The same stream also carries the 8-bit variant codes, which tests the recognition paths together.

// File: rtl/trs_timing_gen.sv
module trs_timing_gen #(
  parameter int LINE_MAX = 2400,
  parameter int HYST     = 7,
  parameter int CVB_LAST = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [9:0] din,
  input  logic       comp_mode,
  input  logic       mark_trs,
  output logic [9:0] dout,
  output logic       hsync,
  output logic       vblank,
  output logic [2:0] field,
  output logic       anc,
  output logic       notrs
);
  localparam int DEPTH = 4;
  localparam int TW    = $clog2(LINE_MAX + 1);
  localparam int HW    = $clog2(HYST + 1);

  logic [9:0]    pipe [DEPTH];
  logic          h_lvl, start_q, vb_q;
  logic [2:0]    fld_q, mark_cnt, pend;
  logic [8:0]    len_r, anc_cnt;
  logic [TW-1:0] timer;
  logic [HW-1:0] miss_cnt, good_cnt;
  logic          notrs_q;

  function automatic logic hi_word(input logic [9:0] w);
    return w[9:2] == 8'hFF;
  endfunction
  function automatic logic lo_word(input logic [9:0] w);
    return w[9:2] == 8'h00;
  endfunction

  wire prefix   = hi_word(pipe[2]) & lo_word(pipe[1]) & lo_word(pipe[0]);
  wire comp_hit = comp_mode & prefix;
  wire cps_hit  = ~comp_mode & prefix & lo_word(din);
  wire trs_hit  = comp_hit | cps_hit;
  wire hdr_hit  = comp_mode & lo_word(pipe[2]) & hi_word(pipe[1]) & hi_word(pipe[0]);
  wire win_end  = timer == TW'(LINE_MAX - 1);
  wire miss     = win_end & ~trs_hit;
  wire [4:0] line_code = din[7:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_lvl    <= 1'b0;
      start_q  <= 1'b0;
      vb_q     <= 1'b0;
      fld_q    <= '0;
      mark_cnt <= '0;
    end else begin
      start_q <= cps_hit;
      if (!comp_mode) h_lvl <= 1'b0;
      else if (comp_hit) h_lvl <= din[4];
      if (comp_hit) begin
        vb_q  <= din[5];
        fld_q <= {2'b00, din[6]};
      end else if (start_q && !comp_mode) begin
        vb_q  <= (line_code != 5'd0) && (int'(line_code) <= CVB_LAST);
        fld_q <= din[2:0];
      end
      if (trs_hit) mark_cnt <= comp_mode ? 3'd4 : 3'd5;
      else if (mark_cnt != 3'd0) mark_cnt <= mark_cnt - 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      len_r   <= '0;
      anc_cnt <= '0;
    end else begin
      pend <= {pend[1:0], hdr_hit};
      if (pend[1]) len_r <= {1'b0, din[7:0]} + 9'd4;
      if (pend[2]) anc_cnt <= len_r;
      else if (anc_cnt != 9'd0) anc_cnt <= anc_cnt - 9'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer    <= '0;
      miss_cnt <= '0;
      good_cnt <= '0;
      notrs_q  <= 1'b0;
    end else begin
      timer <= (trs_hit || win_end) ? '0 : timer + 1'b1;
      if (trs_hit) begin
        miss_cnt <= '0;
        if (good_cnt != HW'(HYST)) good_cnt <= good_cnt + 1'b1;
      end else if (miss) begin
        good_cnt <= '0;
        if (miss_cnt != HW'(HYST)) miss_cnt <= miss_cnt + 1'b1;
      end
      if (!notrs_q && miss && miss_cnt == HW'(HYST - 1)) notrs_q <= 1'b1;
      if (notrs_q && trs_hit && good_cnt == HW'(HYST - 1)) notrs_q <= 1'b0;
    end
  end

  assign dout   = pipe[DEPTH-1];
  assign hsync  = comp_mode ? h_lvl : start_q;
  assign vblank = vb_q;
  assign field  = fld_q;
  assign anc    = (anc_cnt != 9'd0) | (mark_trs & (mark_cnt != 3'd0));
  assign notrs  = notrs_q;

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 3'd4) age <= age + 3'd1;
  end

  AST_FOUR_CYCLE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd4) |-> dout == $past(din, 4)); // R1
  AST_HSYNC_RISE_ON_TRS: assert property (@(posedge clk) disable iff (!rst_n)
    (comp_mode && $past(comp_mode) && $rose(hsync)) |-> dout[9:2] == 8'hFF); // R3
  AST_CPS_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_mode && hsync) |=> !hsync); // R5
  AST_CPS_PULSE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_mode && hsync) |-> dout[9:2] == 8'hFF); // R5
  AST_NOTRS_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(notrs) |-> $past(miss)); // R9
  AST_NOTRS_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(notrs) |-> $past(trs_hit)); // R10
endmodule

// File: tb/trs_timing_gen_tb.sv
module trs_timing_gen_tb;
  localparam int LM = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       comp_mode = 1'b1;
  logic       mark_trs = 1'b0;
  logic [9:0] dout;
  logic       hsync, vblank, anc, notrs;
  logic [2:0] field;

  trs_timing_gen #(.LINE_MAX(LM), .HYST(7), .CVB_LAST(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .comp_mode(comp_mode), .mark_trs(mark_trs),
    .dout(dout), .hsync(hsync), .vblank(vblank), .field(field), .anc(anc), .notrs(notrs));

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [9:0] sw [4096];
  bit         eh [4096];
  bit         ev [4096];
  bit         ea [4096];
  bit         t2 [4096];
  logic [2:0] ef [4096];
  int   n;
  bit   cur_h, cv, alt_seg;
  logic [2:0] cf;

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic put(input logic [9:0] w, input bit h, input bit a);
    sw[n] = w; eh[n] = h; ev[n] = cv; ef[n] = cf; ea[n] = a; t2[n] = alt_seg;
    n++;
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < k; i++) put(10'h040 + 10'(i % 60), comp_mode ? cur_h : 1'b0, 1'b0);
  endtask

  task automatic comp_seq(input bit f, input bit v, input bit h, input bit alt);
    logic [9:0] one, zero;
    one = alt ? 10'h3FC : 10'h3FF;
    zero = alt ? 10'h003 : 10'h000;
    alt_seg = alt;
    cur_h = h; cv = v; cf = {2'b00, f};
    put(one, cur_h, mark_trs);
    put(zero, cur_h, mark_trs);
    put(zero, cur_h, mark_trs);
    put(10'h200 | (10'(f) << 6) | (10'(v) << 5) | (10'(h) << 4), cur_h, mark_trs);
    alt_seg = 1'b0;
  endtask

  task automatic cps_seq(input logic [4:0] code, input logic [2:0] fl, input bit alt);
    logic [9:0] one, zero;
    one = alt ? 10'h3FE : 10'h3FF;
    zero = alt ? 10'h002 : 10'h000;
    alt_seg = alt;
    put(one, 1'b1, mark_trs);
    cv = (code != 5'd0) && (code <= 5'd9);
    cf = fl;
    put(zero, 1'b0, mark_trs);
    put(zero, 1'b0, mark_trs);
    put(zero, 1'b0, mark_trs);
    put(10'h200 | (10'(code) << 3) | 10'(fl), 1'b0, mark_trs);
    alt_seg = 1'b0;
  endtask

  task automatic anc_pkt(input int dc, input bit alt);
    bit a;
    bit h;
    a = comp_mode;
    h = comp_mode ? cur_h : 1'b0;
    alt_seg = alt;
    put(alt ? 10'h001 : 10'h000, h, 1'b0);
    put(alt ? 10'h3FD : 10'h3FF, h, 1'b0);
    put(alt ? 10'h3FD : 10'h3FF, h, 1'b0);
    alt_seg = 1'b0;
    put(10'h140, h, a);
    put(10'h101, h, a);
    put(10'h100 | 10'(dc), h, a);
    for (int j = 0; j < dc; j++) put(10'h080 + 10'(j % 64), h, a);
    put(10'h1AA, h, a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; din = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset dout", int'(dout), 0);
    chk("R1", "reset hsync", int'(hsync), 0);
    chk("R1", "reset vblank", int'(vblank), 0);
    chk("R1", "reset field", int'(field), 0);
    chk("R1", "reset anc", int'(anc), 0);
    chk("R1", "reset notrs", int'(notrs), 0);
    rst_n = 1'b1;
  endtask

  task automatic run_stream();
    for (int j = 0; j < n + 4; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        int k;
        k = j - 4;
        chk(t2[k] ? "R1/R2" : "R1", "dout", int'(dout), int'(sw[k]));
        chk(comp_mode ? "R3" : "R5", "hsync", int'(hsync), int'(eh[k]));
        chk(comp_mode ? "R4" : "R6", "vblank", int'(vblank), int'(ev[k]));
        chk(comp_mode ? "R4" : "R6", "field", int'(field), int'(ef[k]));
        chk(t2[k] ? "R7/R8/R2" : "R7/R8", "anc", int'(anc), int'(ea[k]));
      end
      din = (j < n) ? sw[j] : 10'h040;
    end
  endtask

  task automatic build_comp();
    n = 0; cur_h = 0; cv = 0; cf = '0; alt_seg = 0;
    fill(6);
    for (int fr = 0; fr < 2; fr++)
      for (int vb = 0; vb < 2; vb++)
        for (int al = 0; al < 2; al++) begin
          comp_seq(fr[0], vb[0], 1'b1, al[0]);
          anc_pkt(fr * 5 + vb * 2 + al, al[0]);
          fill(7);
          comp_seq(fr[0], vb[0], 1'b0, al[0]);
          fill(9);
        end
    for (int k = 0; k < 6; k++) begin
      anc_pkt((k == 5) ? 200 : k * k * 3, 1'b0);
      fill(5);
    end
    anc_pkt(5, 1'b0);
    comp_seq(1'b1, 1'b0, 1'b1, 1'b0);
    anc_pkt(2, 1'b0);
    anc_pkt(1, 1'b0);
    comp_seq(1'b0, 1'b0, 1'b0, 1'b0);
    fill(8);
  endtask

  task automatic build_cps();
    n = 0; cur_h = 0; cv = 0; cf = '0; alt_seg = 0;
    fill(6);
    for (int code = 0; code < 32; code++) begin
      cps_seq(5'(code), 3'((code * 3) % 8), (code % 5) == 0);
      fill(6);
      if (code % 4 == 0) anc_pkt(3, 1'b0);
      fill(4);
    end
  endtask

  task automatic drv(input logic [9:0] w);
    @(negedge clk);
    din = w;
  endtask

  task automatic send_trs(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      drv(10'h3FF); drv(10'h000); drv(10'h000); drv(10'h290);
      for (int j = 0; j < 16; j++) drv(10'h040);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    for (int ph = 0; ph < 4; ph++) begin
      comp_mode = (ph < 2);
      mark_trs = ph[0];
      if (comp_mode) build_comp(); else build_cps();
      do_reset();
      run_stream();
    end

    comp_mode = 1'b1; mark_trs = 1'b0;
    do_reset();
    din = 10'h040;
    repeat (6 * LM + LM / 2) @(negedge clk);
    chk("R9", "notrs after six empty windows", int'(notrs), 0);
    repeat (LM) @(negedge clk);
    chk("R9", "notrs after seven empty windows", int'(notrs), 1);
    send_trs(6);
    chk("R10", "notrs after six sequences", int'(notrs), 1);
    send_trs(1);
    chk("R10", "notrs after seven sequences", int'(notrs), 0);
    repeat (8 * LM) @(negedge clk);
    chk("R9", "notrs after long silence", int'(notrs), 1);
    send_trs(4);
    repeat (100) @(negedge clk);
    send_trs(4);
    chk("R10", "notrs after count broken by miss", int'(notrs), 1);
    send_trs(3);
    chk("R10", "notrs after seven since miss", int'(notrs), 0);

    summary();
  end
endmodule